// File: doc/BRIEF.md
# Debug Instruction Transfer Scan Chain

This block is a 33-bit test data register that a debugger uses to hand instruction words to a halted core. It sits behind a TAP controller and does not contain one. The TAP side supplies one-cycle strobes for Capture-DR, Shift-DR, Update-DR and Run-Test/Idle, the serial data pin, the number of the selected chain and a decode of the INTEST and EXTEST instructions. On the core side the block drives a 32-bit instruction holding register and a one-cycle issue strobe. It receives a completion pulse and three status levels: halted, execute-enable and sticky precise abort.

The block keeps a completion flag. The flag falls when an instruction is issued and rises when the core reports that the instruction has finished. The flag is not used directly. A Ready copy of it is latched at every capture on chain 4 or chain 5, and both loading and issuing are gated by that latched copy. Loading happens at Update-DR and needs the instruction chain and EXTEST. Issuing happens at Run-Test/Idle and needs the core status to permit it. The holding register cannot be read back. Capture places the completion flag in the first serial position, followed by 32 zero bits.

Top module: `dbg_itr_chain`

## Requirements
- R1: After synchronous reset the completion flag is 1, the holding register `itr_o` is zero, `issue_o` is low and Ready is 0.
- R2: A Capture-DR strobe, with chain 4 selected and INTEST or EXTEST active, loads the 33-bit shift register. Bit 0, which appears on `tdo` first, holds the completion flag. Bits 32:1 hold zero.
- R3: Each Shift-DR strobe on chain 4 shifts the register one place toward bit 0 and enters `tdi` at bit 32, so `tdo` always shows bit 0.
- R4: An Update-DR strobe with chain 4, EXTEST and Ready = 1 copies shift bits 32:1 into `itr_o`. This happens whatever the halted, execute-enable and abort inputs are.
- R5: `itr_o` is left unchanged at Update-DR when INTEST is active, when another chain is selected, or when Ready is 0, even if the live completion flag is 1.
- R6: A Run-Test/Idle strobe produces a one-cycle `issue_o` pulse one cycle later only when all of the following hold: halted = 1, execute-enable = 1, abort = 0, chain 4 or 5 selected, INTEST or EXTEST active, and Ready = 1.
- R7: If any one of the R6 conditions is false, a Run-Test/Idle strobe gives no `issue_o` pulse.
- R8: The completion flag goes to 0 on the edge that raises `issue_o`. It goes back to 1 after an `instr_done` pulse. The flag is seen through the captured bit 0.
- R9: After an issue, Ready is cleared, so further Run-Test/Idle strobes issue nothing until a later capture latches a completion flag of 1.
- R10: A capture that falls in the same cycle as `instr_done` latches the flag value from before that pulse, both into Ready and into shift bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| upd_dr | input | 1 | Update-DR strobe |
| rti | input | 1 | Run-Test/Idle strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (shift bit 0) |
| chain_sel | input | SEL_W | Selected scan chain number |
| op_intest | input | 1 | INTEST instruction active |
| op_extest | input | 1 | EXTEST instruction active |
| core_halted | input | 1 | Core is in debug state |
| exec_en | input | 1 | Execute-enable status |
| abort_sticky | input | 1 | Sticky precise abort status |
| instr_done | input | 1 | Core finished the issued instruction |
| issue_o | output | 1 | One-cycle issue strobe to the core |
| itr_o | output | DATA_W | Instruction holding register |

## Verification
Two events can land in the same clock edge: the core's completion pulse and the debugger's Capture-DR. To provoke this, the bench issues an instruction, then raises `instr_done` and `cap_dr` in the same cycle. It checks that the captured bit shifted out is 0 and that a following Update-DR leaves `itr_o` unchanged. It then checks that the next capture returns 1 and that the next load succeeds.

// File: rtl/dbg_itr_pkg.sv
package dbg_itr_pkg;
  localparam int unsigned ITR_DATA_W  = 32;
  localparam int unsigned CHAIN_SEL_W = 5;
  localparam int unsigned ITR_CHAIN   = 4;
  localparam int unsigned DTR_CHAIN   = 5;

  typedef struct packed {
    logic halted;
    logic exec_en;
    logic abort;
  } core_stat_t;
endpackage

// File: rtl/dbg_itr_shreg.sv
module dbg_itr_shreg #(
  parameter int unsigned W = 33
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic         shift_en,
  input  logic [W-1:0] cap_val,
  input  logic         tdi,
  output logic [W-1:0] sr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0;
    end else if (cap_en) begin
      sr <= cap_val;
    end else if (shift_en) begin
      sr <= {tdi, sr[W-1:1]};
    end
  end

  // R3: a shift moves the register one place toward bit 0
  p_shift_moves_r3: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !cap_en) |=> (sr[W-2:0] == $past(sr[W-1:1])));
endmodule

// File: rtl/dbg_itr_ctrl.sv
module dbg_itr_ctrl (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cap_en,
  input  logic                    rti,
  input  logic                    issue_gate,
  input  logic                    upd_dr,
  input  logic                    load_gate,
  input  logic                    instr_done,
  output logic                    cmpl,
  output logic                    ready_q,
  output logic                    issue_o,
  output logic                    load_o
);
  logic issue_go;

  assign issue_go = rti && issue_gate && ready_q;
  assign load_o   = upd_dr && load_gate && ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpl    <= 1'b1;
      ready_q <= 1'b0;
      issue_o <= 1'b0;
    end else begin
      issue_o <= issue_go;
      if (issue_go)        cmpl <= 1'b0;
      else if (instr_done) cmpl <= 1'b1;
      if (issue_go)        ready_q <= 1'b0;
      else if (cap_en)     ready_q <= cmpl;
    end
  end

  // R8: the completion flag is low on the edge that raises issue
  p_issue_clears_r8: assert property (@(posedge clk) disable iff (rst)
    issue_o |-> !cmpl);
  // R8: a completion pulse with no issue sets the flag
  p_done_sets_r8: assert property (@(posedge clk) disable iff (rst)
    (instr_done && !rti) |=> cmpl);
  // R9: issue is a single-cycle pulse
  p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    issue_o |=> !issue_o);
  // R10: Ready takes the flag value from before the capture edge
  p_ready_capture_r10: assert property (@(posedge clk) disable iff (rst)
    (cap_en && !rti) |=> (ready_q == $past(cmpl)));
endmodule

// File: rtl/dbg_itr_hold.sv
module dbg_itr_hold #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] itr
);
  always_ff @(posedge clk) begin
    if (rst)       itr <= '0;
    else if (load) itr <= din;
  end

  // R5: the holding register changes only after a granted load
  p_itr_only_on_load_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(itr) |-> $past(load));
endmodule

// File: rtl/dbg_itr_chain.sv
module dbg_itr_chain
  import dbg_itr_pkg::*;
#(
  parameter int unsigned DATA_W = ITR_DATA_W,
  parameter int unsigned SEL_W  = CHAIN_SEL_W,
  parameter int unsigned CH_ITR = ITR_CHAIN,
  parameter int unsigned CH_DTR = DTR_CHAIN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_dr,
  input  logic              shift_dr,
  input  logic              upd_dr,
  input  logic              rti,
  input  logic              tdi,
  output logic              tdo,
  input  logic [SEL_W-1:0]  chain_sel,
  input  logic              op_intest,
  input  logic              op_extest,
  input  logic              core_halted,
  input  logic              exec_en,
  input  logic              abort_sticky,
  input  logic              instr_done,
  output logic              issue_o,
  output logic [DATA_W-1:0] itr_o
);
  localparam int unsigned CHAIN_W = DATA_W + 1;
  localparam logic [SEL_W-1:0] SEL_ITR = SEL_W'(CH_ITR);
  localparam logic [SEL_W-1:0] SEL_DTR = SEL_W'(CH_DTR);

  core_stat_t         stat;
  logic               sel_itr, sel_any, test_op;
  logic               ready_cap, sr_cap, sr_shift;
  logic               issue_gate, load_gate, load;
  logic               cmpl, ready_q;
  logic [CHAIN_W-1:0] sr, cap_val;

  assign stat       = '{halted: core_halted, exec_en: exec_en, abort: abort_sticky};
  assign sel_itr    = (chain_sel == SEL_ITR);
  assign sel_any    = sel_itr || (chain_sel == SEL_DTR);
  assign test_op    = op_intest || op_extest;
  assign ready_cap  = cap_dr && sel_any && test_op;
  assign sr_cap     = cap_dr && sel_itr && test_op;
  assign sr_shift   = shift_dr && sel_itr && test_op;
  assign issue_gate = stat.halted && stat.exec_en && !stat.abort && sel_any && test_op;
  assign load_gate  = sel_itr && op_extest;
  assign cap_val    = {{DATA_W{1'b0}}, cmpl};

  dbg_itr_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .cap_en     (ready_cap),
    .rti        (rti),
    .issue_gate (issue_gate),
    .upd_dr     (upd_dr),
    .load_gate  (load_gate),
    .instr_done (instr_done),
    .cmpl       (cmpl),
    .ready_q    (ready_q),
    .issue_o    (issue_o),
    .load_o     (load)
  );

  dbg_itr_shreg #(.W(CHAIN_W)) u_shreg (
    .clk      (clk),
    .rst      (rst),
    .cap_en   (sr_cap),
    .shift_en (sr_shift),
    .cap_val  (cap_val),
    .tdi      (tdi),
    .sr       (sr)
  );

  dbg_itr_hold #(.W(DATA_W)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .din  (sr[CHAIN_W-1:1]),
    .itr  (itr_o)
  );

  assign tdo = sr[0];

  // R2: capture on the instruction chain presents the flag first, then zeros
  p_capture_layout_r2: assert property (@(posedge clk) disable iff (rst)
    (sr_cap && !instr_done && !rti) |=> (sr == {{DATA_W{1'b0}}, $past(cmpl)}));
  // R6: an issue pulse follows only a permitted Run-Test/Idle strobe
  p_issue_needs_rti_r6: assert property (@(posedge clk) disable iff (rst)
    issue_o |-> $past(rti && issue_gate));
endmodule

// File: tb/tb_dbg_itr_chain.sv
`timescale 1ns/1ps
module tb_dbg_itr_chain;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cap_dr = 0, shift_dr = 0, upd_dr = 0, rti = 0, tdi = 0;
  logic [4:0]  chain_sel = 5'd4;
  logic        op_intest = 0, op_extest = 1;
  logic        core_halted = 0, exec_en = 0, abort_sticky = 0, instr_done = 0;
  logic        tdo, issue_o;
  logic [31:0] itr_o;
  int nvec = 0, nfail = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  dbg_itr_chain dut (
    .clk(clk), .rst(rst), .cap_dr(cap_dr), .shift_dr(shift_dr), .upd_dr(upd_dr),
    .rti(rti), .tdi(tdi), .tdo(tdo), .chain_sel(chain_sel), .op_intest(op_intest),
    .op_extest(op_extest), .core_halted(core_halted), .exec_en(exec_en),
    .abort_sticky(abort_sticky), .instr_done(instr_done), .issue_o(issue_o), .itr_o(itr_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe_cap();
    cap_dr = 1; @(negedge clk); cap_dr = 0;
  endtask
  task automatic strobe_upd();
    upd_dr = 1; @(negedge clk); upd_dr = 0;
  endtask
  task automatic strobe_rti();
    rti = 1; @(negedge clk); rti = 0;
  endtask
  task automatic shift33(input logic [32:0] din, output logic [32:0] dout);
    for (int i = 0; i < 33; i++) begin
      dout[i] = tdo; tdi = din[i]; shift_dr = 1; @(negedge clk);
    end
    shift_dr = 0;
  endtask
  task automatic set_ok();
    chain_sel = 5'd4; op_extest = 1; op_intest = 0;
    core_halted = 1; exec_en = 1; abort_sticky = 0;
  endtask
  task automatic pulse_done();
    instr_done = 1; @(negedge clk); instr_done = 0;
  endtask

  task automatic t_reset();
    logic [32:0] o;
    check(itr_o == 0, "R1 itr reset", itr_o, 0);
    check(issue_o == 0, "R1 issue reset", issue_o, 0);
    set_ok(); strobe_rti();
    check(issue_o == 0, "R1 ready zero after reset", issue_o, 0);
    strobe_cap();
    shift33('0, o);
    check(o == 33'h1, "R2 capture layout", o, 33'h1);
    strobe_upd();
  endtask

  task automatic t_load();
    logic [32:0] o;
    chain_sel = 5'd4; op_extest = 1; op_intest = 0;
    core_halted = 0; exec_en = 0; abort_sticky = 1;
    strobe_cap();
    shift33({32'hA5C3_1E69, 1'b0}, o);
    check(o == 33'h1, "R3 shifted-out bits", o, 33'h1);
    strobe_upd();
    check(itr_o == 32'hA5C3_1E69, "R4 load ignoring core status", itr_o, 32'hA5C3_1E69);
    op_extest = 0; op_intest = 1;
    strobe_cap(); shift33({32'h1111_2222, 1'b0}, o); strobe_upd();
    check(itr_o == 32'hA5C3_1E69, "R5 no load under INTEST", itr_o, 32'hA5C3_1E69);
    op_intest = 0; op_extest = 1; strobe_cap();
    shift33({32'h3333_4444, 1'b0}, o);
    chain_sel = 5'd5; strobe_upd();
    check(itr_o == 32'hA5C3_1E69, "R5 no load on chain 5", itr_o, 32'hA5C3_1E69);
    chain_sel = 5'd4;
  endtask

  task automatic t_issue();
    logic [32:0] o;
    set_ok(); strobe_cap(); strobe_rti();
    check(issue_o == 1, "R6 issue pulse", issue_o, 1);
    @(negedge clk);
    check(issue_o == 0, "R6 pulse width one", issue_o, 0);
    strobe_rti();
    check(issue_o == 0, "R9 no reissue before capture", issue_o, 0);
    strobe_cap();
    shift33({32'h5555_AAAA, 1'b0}, o);
    check(o[0] == 0, "R8 flag clear after issue", o[0], 0);
    strobe_upd();
    check(itr_o == 32'hA5C3_1E69, "R5 no load with Ready 0", itr_o, 32'hA5C3_1E69);
    strobe_rti();
    check(issue_o == 0, "R9 still blocked while busy", issue_o, 0);
    pulse_done();
    strobe_cap();
    shift33({32'hDEAD_BEEF, 1'b0}, o);
    check(o[0] == 1, "R8 flag set after done", o[0], 1);
    strobe_upd();
    check(itr_o == 32'hDEAD_BEEF, "R4 load after completion", itr_o, 32'hDEAD_BEEF);
  endtask

  task automatic t_refuse();
    for (int k = 0; k < 5; k++) begin
      set_ok(); strobe_cap();
      case (k)
        0: core_halted = 0;
        1: exec_en = 0;
        2: abort_sticky = 1;
        3: chain_sel = 5'd3;
        default: op_extest = 0;
      endcase
      strobe_rti();
      check(issue_o == 0, $sformatf("R7 refused case %0d", k), issue_o, 0);
    end
    set_ok(); chain_sel = 5'd5; op_extest = 0; op_intest = 1;
    strobe_cap(); strobe_rti();
    check(issue_o == 1, "R6 issue via chain 5 INTEST", issue_o, 1);
    @(negedge clk); pulse_done();
  endtask

  task automatic t_coincide();
    logic [32:0] o;
    set_ok(); strobe_cap(); strobe_rti();
    check(issue_o == 1, "R6 issue before coincidence", issue_o, 1);
    @(negedge clk);
    instr_done = 1; cap_dr = 1; @(negedge clk); instr_done = 0; cap_dr = 0;
    shift33({32'h0BAD_F00D, 1'b0}, o);
    check(o[0] == 0, "R10 capture sees old flag", o[0], 0);
    strobe_upd();
    check(itr_o == 32'hDEAD_BEEF, "R10 load refused on stale Ready", itr_o, 32'hDEAD_BEEF);
    strobe_cap();
    shift33({32'h0BAD_F00D, 1'b0}, o);
    check(o[0] == 1, "R10 next capture sees completion", o[0], 1);
    strobe_upd();
    check(itr_o == 32'h0BAD_F00D, "R10 load accepted afterwards", itr_o, 32'h0BAD_F00D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_load();
    t_issue();
    t_refuse();
    t_coincide();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done_flag) begin
      done_flag = 1;
      nvec++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule